// File: doc/BRIEF.md
# Parallel Port FIFO Service Request Logic

This block is the transfer buffer of an extended-capabilities parallel port, together with the logic that decides when the host should service it. A 16-entry byte FIFO sits between a host register interface and a peripheral-side byte stream. The host chooses a direction: forward (host to peripheral) or reverse (peripheral to host). The host also sets a DMA enable bit, a service mask bit and a test-mode bit, and programs an occupancy threshold. Each FIFO entry keeps one tag bit. The tag tells the peripheral-side consumer whether the byte arrived through the data port or through the address port.

In programmed I/O mode (DMA enable 0, service mask 0) the block raises `irq`. In reverse, it does so once enough bytes are waiting to be read. In forward, it does so once enough room is free to write. In DMA mode it raises `dma_req` instead. A terminal-count pulse sets the service mask, and that mask keeps the request down until software clears it again. Test mode joins both host ports to the FIFO, so software can measure the depth and the thresholds by itself.

Both peripheral-side streams use valid/ready. A byte moves on a clock edge only when valid and ready are both high. The FIFO deasserts `pin_ready` when it is full and `pout_valid` when it is empty. Both sides are idle in test mode and during a flush cycle. `pin_data` needs to be stable only while `pin_valid` is high. The consumer may hold `pout_ready` high at any time.

Top module: `ppfifo_service`

## Requirements
- R1: The FIFO holds 16 entries in first-in first-out order. `fifo_full` is 1 at 16 entries and `fifo_empty` is 1 at 0 entries, with no further writes accepted when full.
- R2: Host port decode uses two offsets, 0x400 for data and 0x000 for the address port. In forward mode outside test mode, host writes push: a write to 0x400 pushes with tag 0 and a write to 0x000 pushes with tag 1. In reverse mode outside test mode, host reads from 0x400 pop and host writes are ignored. In test mode, host writes and reads at 0x400 push and pop. Any other access is ignored and leaves the occupancy unchanged.
- R3: Outside test mode, `pout_valid` is 1 in forward mode when the FIFO is not empty, and `pout_data`/`pout_cmd` show the oldest entry. `pin_ready` is 1 in reverse mode when the FIFO is not full. A transfer happens when valid and ready are both 1.
- R4: In reverse mode the interrupt condition is occupancy ≥ 16 − threshold. For example, a threshold of 12 gives 4 to 16 bytes.
- R5: In forward mode the interrupt condition is occupancy ≤ threshold. For example, a threshold of 12 gives 0 to 12 bytes.
- R6: The threshold field is 5 bits wide. Any value above 15, including 16, behaves exactly as 15.
- R7: `irq` follows the interrupt condition one clock after the occupancy or the control register changes. `irq` is 0 while the service mask or the DMA enable is 1.
- R8: With DMA enable 1 and service mask 0, `dma_req` is 1 one clock after the FIFO holds at least one byte (reverse) or has at least one free entry (forward).
- R9: A `dma_tc` pulse while DMA is enabled sets the service mask, so `dma_req` is 0 from the next clock. The request returns only after a control write clears the mask and the FIFO condition of R8 holds.
- R10: A host write to a full FIFO and a host read from an empty FIFO, on an enabled port, leave the FIFO unchanged. They set the sticky flags `ovf_flag` and `udf_flag` respectively, and any control write clears both flags.
- R11: A control write that changes direction flushes the FIFO to 0 entries and drops `irq` and `dma_req` for at least one clock. Any push or pop in that same cycle is discarded.
- R12: After reset the block is in forward mode, not in test mode, with DMA off, the service mask set, threshold 0, the FIFO empty, both flags clear, and `irq` and `dma_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops on the edge) |
| host_addr | input | 11 | Host port offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Oldest FIFO byte, valid before the read strobe |
| ctl_wr | input | 1 | Control register load strobe |
| ctl_dir | input | 1 | Direction: 0 forward, 1 reverse |
| ctl_dma_en | input | 1 | DMA enable |
| ctl_svc | input | 1 | Service mask (1 masks requests) |
| ctl_test | input | 1 | Test mode |
| ctl_thr | input | 5 | Occupancy threshold |
| dma_tc | input | 1 | DMA terminal-count pulse |
| pin_valid | input | 1 | Peripheral byte offered (reverse) |
| pin_ready | output | 1 | FIFO accepts peripheral byte |
| pin_data | input | 8 | Peripheral byte in |
| pout_valid | output | 1 | Byte offered to peripheral (forward) |
| pout_ready | input | 1 | Peripheral takes byte |
| pout_data | output | 8 | Byte to peripheral |
| pout_cmd | output | 1 | Tag: 1 if written through the address port |
| irq | output | 1 | Programmed I/O service request |
| dma_req | output | 1 | DMA service request |
| fifo_full | output | 1 | FIFO holds 16 entries |
| fifo_empty | output | 1 | FIFO holds no entries |
| ovf_flag | output | 1 | Sticky write-when-full flag |
| udf_flag | output | 1 | Sticky read-when-empty flag |

## Verification
The occupancy counter is internal, but any error in it shows on `fifo_full` and `fifo_empty` on the same edge. It also shows one clock later on `irq`, which changes state at a threshold boundary, so the bench steps occupancy one byte at a time across the threshold in both directions. A bad pointer shows as a wrong byte or tag on `host_rdata` or `pout_data` at the next pop. A service mask that fails to set or clear after terminal count shows on `dma_req` within one clock. A threshold of 16 at zero occupancy separates saturation from plain subtraction at once.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;

  typedef struct packed {
    dir_e       dir;
    logic       dma_en;
    logic       svc;
    logic       test;
    logic [4:0] thr;
  } ctl_t;

endpackage

// File: rtl/ppf_store.sv
module ppf_store #(
  parameter int DEPTH = 16,
  parameter int EW    = 9,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [EW-1:0]    wdata,
  output logic [EW-1:0]    rdata,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             empty
);

  logic [EW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R1
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R10
  AST_POP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R11

endmodule

// File: rtl/ppf_ctl.sv
module ppf_ctl
  import ppf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  ctl_t ctl_in,
  input  logic tc,
  input  logic ovf_evt,
  input  logic udf_evt,
  output ctl_t ctl_q,
  output logic flush,
  output logic ovf,
  output logic udf
);

  assign flush = ctl_wr && (ctl_in.dir != ctl_q.dir);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '{dir: DIR_FWD, dma_en: 1'b0, svc: 1'b1, test: 1'b0, thr: 5'd0};
    end else begin
      if (ctl_wr) ctl_q <= ctl_in;
      if (tc && ctl_q.dma_en) ctl_q.svc <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      if (ctl_wr)  begin ovf <= 1'b0; udf <= 1'b0; end
      if (ovf_evt) ovf <= 1'b1;
      if (udf_evt) udf <= 1'b1;
    end
  end

  AST_TC_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && ctl_q.dma_en) |=> ctl_q.svc); // R9

endmodule

// File: rtl/ppf_req.sv
module ppf_req
  import ppf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int THR_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [CNT_W-1:0] cnt,
  input  dir_e             dir,
  input  logic [THR_W-1:0] thr,
  input  logic             svc,
  input  logic             dma_en,
  output logic             irq,
  output logic             dma_req
);

  logic [CNT_W-1:0] thr_eff;
  logic             hit_pio, hit_dma;
  logic             irq_q, dreq_q;

  always_comb begin
    if (thr > THR_W'(DEPTH - 1)) thr_eff = CNT_W'(DEPTH - 1);
    else                         thr_eff = CNT_W'(thr);
  end

  always_comb begin
    if (dir == DIR_REV) begin
      hit_pio = (cnt >= (CNT_W'(DEPTH) - thr_eff));
      hit_dma = (cnt != '0);
    end else begin
      hit_pio = (cnt <= thr_eff);
      hit_dma = (cnt != CNT_W'(DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      irq_q  <= 1'b0;
      dreq_q <= 1'b0;
    end else begin
      irq_q  <= hit_pio;
      dreq_q <= hit_dma;
    end
  end

  assign irq     = irq_q && !svc && !dma_en;
  assign dma_req = dreq_q && dma_en && !svc;

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!irq && !dma_req)); // R11
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req)); // R7

endmodule

// File: rtl/ppfifo_service.sv
module ppfifo_service
  import ppf_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter int          DW        = 8,
  parameter int          AW        = 11,
  parameter int          THR_W     = 5,
  parameter logic [10:0] DFIFO_OFS = 11'h400,
  parameter logic [10:0] AFIFO_OFS = 11'h000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          ctl_wr,
  input  logic          ctl_dir,
  input  logic          ctl_dma_en,
  input  logic          ctl_svc,
  input  logic          ctl_test,
  input  logic [THR_W-1:0] ctl_thr,
  input  logic          dma_tc,
  input  logic          pin_valid,
  output logic          pin_ready,
  input  logic [DW-1:0] pin_data,
  output logic          pout_valid,
  input  logic          pout_ready,
  output logic [DW-1:0] pout_data,
  output logic          pout_cmd,
  output logic          irq,
  output logic          dma_req,
  output logic          fifo_full,
  output logic          fifo_empty,
  output logic          ovf_flag,
  output logic          udf_flag
);

  localparam int EW    = DW + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  ctl_t             ctl_in, ctl_q;
  logic             flush;
  logic [EW-1:0]    wr_entry, head;
  logic [CNT_W-1:0] cnt;
  logic             at_data, at_addr;
  logic             wr_try, rd_try, push, pop;
  logic             fwd, rev;

  assign ctl_in = '{dir: dir_e'(ctl_dir), dma_en: ctl_dma_en, svc: ctl_svc,
                    test: ctl_test, thr: ctl_thr};

  assign fwd     = (ctl_q.dir == DIR_FWD) && !ctl_q.test;
  assign rev     = (ctl_q.dir == DIR_REV) && !ctl_q.test;
  assign at_data = (host_addr == AW'(DFIFO_OFS));
  assign at_addr = (host_addr == AW'(AFIFO_OFS));

  assign wr_try = host_wr && ((fwd && (at_data || at_addr)) || (ctl_q.test && at_data));
  assign rd_try = host_rd && at_data && (rev || ctl_q.test);

  assign pin_ready  = rev && !fifo_full && !flush;
  assign pout_valid = fwd && !fifo_empty && !flush;

  assign push = !flush && ((wr_try && !fifo_full) || (pin_valid && pin_ready));
  assign pop  = !flush && ((rd_try && !fifo_empty) || (pout_valid && pout_ready));

  always_comb begin
    if (rev) wr_entry = {1'b0, pin_data};
    else     wr_entry = {(fwd && at_addr), host_wdata};
  end

  assign host_rdata = head[DW-1:0];
  assign pout_data  = head[DW-1:0];
  assign pout_cmd   = head[EW-1];

  ppf_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_wr  (ctl_wr),
    .ctl_in  (ctl_in),
    .tc      (dma_tc),
    .ovf_evt (wr_try && fifo_full && !flush),
    .udf_evt (rd_try && fifo_empty && !flush),
    .ctl_q   (ctl_q),
    .flush   (flush),
    .ovf     (ovf_flag),
    .udf     (udf_flag)
  );

  ppf_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .wdata (wr_entry),
    .rdata (head),
    .cnt   (cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  ppf_req #(.DEPTH(DEPTH), .THR_W(THR_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .cnt     (cnt),
    .dir     (ctl_q.dir),
    .thr     (ctl_q.thr),
    .svc     (ctl_q.svc),
    .dma_en  (ctl_q.dma_en),
    .irq     (irq),
    .dma_req (dma_req)
  );

  AST_PIN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ready |-> !fifo_full); // R3
  AST_TC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tc && ctl_q.dma_en && !ctl_wr) |=> !dma_req); // R9
  AST_IDLE_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.test |-> (!pin_ready && !pout_valid)); // R3

endmodule

// File: tb/ppfifo_service_tb_top.sv
module ppfifo_service_tb_top;

  localparam logic [2:0] OP_CTL = 3'd0, OP_HWD = 3'd1, OP_HWA = 3'd2, OP_HRD = 3'd3,
                         OP_POUT = 3'd4, OP_PIN = 3'd5, OP_TC = 3'd6;
  localparam int NV = 34;
  // {op, arg, exp irq, exp dma_req, exp full, exp empty}
  // ctl arg: [8] dir, [7] dma_en, [6] svc, [5] test, [4:0] threshold
  localparam logic [22:0] VEC [NV] = '{
    {OP_CTL, 16'h0002, 4'b1001}, {OP_HWD, 16'h00A1, 4'b1000},
    {OP_HWA, 16'h005C, 4'b1000}, {OP_HWD, 16'h00A3, 4'b0000},
    {OP_POUT,16'h00A1, 4'b1000}, {OP_POUT,16'h015C, 4'b1000},
    {OP_HRD, 16'h00A3, 4'b1000}, {OP_POUT,16'h00A3, 4'b1001},
    {OP_CTL, 16'h0010, 4'b1001}, {OP_CTL, 16'h010C, 4'b0001},
    {OP_PIN, 16'h0011, 4'b0000}, {OP_PIN, 16'h0022, 4'b0000},
    {OP_PIN, 16'h0033, 4'b0000}, {OP_PIN, 16'h0044, 4'b1000},
    {OP_HRD, 16'h0011, 4'b0000}, {OP_HWD, 16'h0099, 4'b0000},
    {OP_PIN, 16'h0055, 4'b1000}, {OP_CTL, 16'h014C, 4'b0000},
    {OP_CTL, 16'h010C, 4'b1000}, {OP_CTL, 16'h0103, 4'b0000},
    {OP_CTL, 16'h0100, 4'b0000}, {OP_CTL, 16'h0180, 4'b0100},
    {OP_HRD, 16'h0022, 4'b0100}, {OP_TC,  16'h0000, 4'b0000},
    {OP_HRD, 16'h0033, 4'b0000}, {OP_CTL, 16'h0180, 4'b0100},
    {OP_HRD, 16'h0044, 4'b0100}, {OP_HRD, 16'h0055, 4'b0001},
    {OP_PIN, 16'h0066, 4'b0100}, {OP_CTL, 16'h0080, 4'b0101},
    {OP_CTL, 16'h0020, 4'b1001}, {OP_HWA, 16'h0012, 4'b1001},
    {OP_HWD, 16'h0077, 4'b0000}, {OP_HRD, 16'h0077, 4'b1001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, ctl_wr = 0, ctl_dir = 0, ctl_dma_en = 0, ctl_svc = 0;
  logic ctl_test = 0, dma_tc = 0, pin_valid = 0, pout_ready = 0;
  logic [10:0] host_addr = '0;
  logic [7:0]  host_wdata = '0, pin_data = '0;
  logic [4:0]  ctl_thr = '0;
  logic [7:0]  host_rdata, pout_data;
  logic pin_ready, pout_valid, pout_cmd, irq, dma_req, fifo_full, fifo_empty, ovf_flag, udf_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ppfifo_service dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ctl_wr(ctl_wr), .ctl_dir(ctl_dir),
    .ctl_dma_en(ctl_dma_en), .ctl_svc(ctl_svc), .ctl_test(ctl_test), .ctl_thr(ctl_thr),
    .dma_tc(dma_tc), .pin_valid(pin_valid), .pin_ready(pin_ready), .pin_data(pin_data),
    .pout_valid(pout_valid), .pout_ready(pout_ready), .pout_data(pout_data),
    .pout_cmd(pout_cmd), .irq(irq), .dma_req(dma_req), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // drive at a falling edge, apply on the rising edge, then one settle edge
  task automatic do_op(input logic [2:0] op, input logic [15:0] arg);
    case (op)
      OP_CTL: begin
        ctl_wr = 1; ctl_dir = arg[8]; ctl_dma_en = arg[7]; ctl_svc = arg[6];
        ctl_test = arg[5]; ctl_thr = arg[4:0];
      end
      OP_HWD: begin host_wr = 1; host_addr = 11'h400; host_wdata = arg[7:0]; end
      OP_HWA: begin host_wr = 1; host_addr = 11'h000; host_wdata = arg[7:0]; end
      OP_HRD: begin host_rd = 1; host_addr = 11'h400; end
      OP_POUT: pout_ready = 1;
      OP_PIN: begin pin_valid = 1; pin_data = arg[7:0]; end
      default: dma_tc = 1;
    endcase
    step();
    ctl_wr = 0; host_wr = 0; host_rd = 0; pout_ready = 0; pin_valid = 0; dma_tc = 0;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    check("R12 irq", {15'd0, irq}, 16'd0);
    check("R12 dma_req", {15'd0, dma_req}, 16'd0);
    check("R12 empty/full", {14'd0, fifo_empty, fifo_full}, 16'd2);
    check("R12 flags", {14'd0, ovf_flag, udf_flag}, 16'd0);
    check("R12 stream idle", {14'd0, pin_ready, pout_valid}, 16'd0);
    step();
    check("R12 irq masked after reset", {15'd0, irq}, 16'd0);

    // table walk: R2 R3 R4 R5 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [15:0] arg;
      op  = VEC[i][22:20];
      arg = VEC[i][19:4];
      if (op == OP_HRD) check($sformatf("R2 vec%0d rdata", i), {8'd0, host_rdata}, {8'd0, arg[7:0]});
      if (op == OP_POUT) check($sformatf("R3 vec%0d pout", i),
                               {6'd0, pout_valid, pout_cmd, pout_data}, {6'd0, 1'b1, arg[8:0]});
      do_op(op, arg);
      check($sformatf("R4 R5 R7 R8 R9 R11 vec%0d irq/dreq/full/empty", i),
            {12'd0, irq, dma_req, fifo_full, fifo_empty}, {12'd0, VEC[i][3:0]});
    end

    // R1 R10 depth through the test port (test mode, forward, threshold 0)
    for (int i = 0; i < 16; i++) do_op(OP_HWD, 16'(8'h30 + i));
    check("R1 full at 16", {14'd0, fifo_full, fifo_empty}, 16'd2);
    do_op(OP_HWD, 16'h00EE);
    check("R10 overflow flag", {14'd0, ovf_flag, fifo_full}, 16'd3);
    for (int i = 0; i < 16; i++) begin
      check("R1 order", {8'd0, host_rdata}, 16'(8'h30 + i));
      do_op(OP_HRD, 16'h0);
    end
    check("R1 empty after drain", {15'd0, fifo_empty}, 16'd1);
    do_op(OP_HRD, 16'h0);
    check("R10 underflow flag", {14'd0, ovf_flag, udf_flag}, 16'd3);
    check("R10 empty unchanged", {15'd0, fifo_empty}, 16'd1);
    do_op(OP_CTL, 16'h0020);
    check("R10 flags cleared", {14'd0, ovf_flag, udf_flag}, 16'd0);

    // R4 reverse threshold 12
    do_op(OP_CTL, 16'h010C);
    check("R4 irq at 0", {15'd0, irq}, 16'd0);
    for (int n = 1; n <= 16; n++) begin
      do_op(OP_PIN, 16'(n));
      check($sformatf("R4 irq at %0d", n), {15'd0, irq}, {15'd0, n >= 4});
    end
    check("R3 pin_ready low when full", {14'd0, pin_ready, fifo_full}, 16'd1);

    // R5 forward threshold 12 (direction change flushes, R11)
    do_op(OP_CTL, 16'h000C);
    check("R11 flushed", {14'd0, fifo_empty, pout_valid}, 16'd2);
    for (int n = 1; n <= 16; n++) begin
      do_op(OP_HWD, 16'(8'h80 + n));
      check($sformatf("R5 irq at %0d", n), {15'd0, irq}, {15'd0, n <= 12});
    end
    check("R3 pout_valid", {15'd0, pout_valid}, 16'd1);
    for (int n = 1; n <= 3; n++) begin
      check("R3 pout order", {7'd0, pout_cmd, pout_data}, 16'(8'h80 + n));
      do_op(OP_POUT, 16'h0);
    end

    // R6 threshold 16 behaves as 15
    do_op(OP_CTL, 16'h0110);
    check("R6 thr16 at 0", {15'd0, irq}, 16'd0);
    do_op(OP_PIN, 16'h0001);
    check("R6 thr16 at 1", {15'd0, irq}, 16'd1);
    do_op(OP_CTL, 16'h010F);
    check("R6 thr15 at 1", {15'd0, irq}, 16'd1);

    // R8 forward DMA drops when full
    do_op(OP_CTL, 16'h0080);
    check("R8 forward dreq empty", {15'd0, dma_req}, 16'd1);
    for (int n = 1; n <= 16; n++) do_op(OP_HWD, 16'(n));
    check("R8 forward dreq full", {14'd0, dma_req, fifo_full}, 16'd1);

    finish_run();
  end

endmodule